// File: doc/BRIEF.md
# Raw Receive Tap Activity Monitor

This block observes a complex receive sample stream (I, Q and a valid strobe) at the point where samples leave the converter. It has not yet passed through any format correction. It condenses what it has seen into one 32-bit debug word. The word holds five sticky flags, a truncated count of valid beats and a running peak of the sample magnitude. The flags record that a beat arrived, that a beat carried non-zero data, that a beat came while the BER engine was active, and that I or Q went negative.

The word is built from the samples exactly as they arrive. A downstream stage may reinterpret the sample format, but that does not change what the monitor reports. A bring-up engineer can therefore tell a dead path, a silent path and a path with a format mismatch apart by reading one register. A synchronous clear input returns all the accumulated state to zero. The word is a plain output meant to feed a register readback path.

Top module: `tap_activity_monitor`

## Requirements
- R1: After reset the debug word reads 0x0000_0000.
- R2: Bit 31 becomes 1 after the first valid beat and stays 1 until clear or reset.
- R3: Bit 30 becomes 1 after a valid beat whose I or Q is non-zero. Valid beats with both I and Q equal to zero leave it at 0.
- R4: Bit 29 becomes 1 after a valid beat that arrives while the engine-active input is 1. Valid beats with engine-active at 0 leave it at 0.
- R5: Bit 28 becomes 1 after a valid beat whose raw I has its sign bit (bit 15) set. Bit 27 does the same for raw Q. No format correction is applied, so 0x8000 counts as negative.
- R6: Bits 26:14 hold the number of valid beats modulo 8192. The count wraps from 8191 to 0.
- R7: Bits 13:0 hold the largest value of max(|I|, |Q|) over all valid beats, with I and Q taken as 16-bit two's complement. The value saturates at 16383, and |-32768| is taken as 32767.
- R8: While valid is 0, the word does not change, whatever the I, Q and engine-active inputs do.
- R9: A cycle with clear at 1 makes the word 0 on the next cycle. A valid beat in the same cycle as clear is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all flags, the count and the peak |
| smp_valid | input | 1 | Sample beat strobe |
| smp_i | input | 16 | Raw I sample |
| smp_q | input | 16 | Raw Q sample |
| engine_active | input | 1 | BER engine active level |
| dbg_word | output | 32 | Packed activity word |

## Verification
A clear and a valid beat can arrive in the same cycle. The bench provokes this by presenting a large negative beat with engine-active high in the very cycle that clear is asserted. It then requires the word to read zero on the next cycle, with no trace of the flags, count or peak that the beat would have set. The bench also checks that the beat immediately after the clear is counted as the first one.

// File: rtl/tap_activity_monitor.sv
module tap_activity_monitor #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 13,
  parameter int PEAK_W   = 14
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic                             smp_valid,
  input  logic [SAMPLE_W-1:0]              smp_i,
  input  logic [SAMPLE_W-1:0]              smp_q,
  input  logic                             engine_active,
  output logic [5+CNT_W+PEAK_W-1:0]        dbg_word
);
  localparam logic [SAMPLE_W-1:0] ONE      = {{(SAMPLE_W-1){1'b0}}, 1'b1};
  localparam logic [SAMPLE_W-1:0] POS_MAX  = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [PEAK_W-1:0]   PEAK_MAX = {PEAK_W{1'b1}};
  localparam logic [CNT_W-1:0]    CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic              seen_valid, seen_nz, seen_busy, seen_neg_i, seen_neg_q;
  logic [CNT_W-1:0]  beat_cnt;
  logic [PEAK_W-1:0] peak;

  logic [SAMPLE_W-1:0] mag_i, mag_q, mag_big;
  logic [PEAK_W-1:0]   mag_sat;

  assign mag_i = !smp_i[SAMPLE_W-1] ? smp_i :
                 (smp_i[SAMPLE_W-2:0] == '0) ? POS_MAX : (~smp_i + ONE);
  assign mag_q = !smp_q[SAMPLE_W-1] ? smp_q :
                 (smp_q[SAMPLE_W-2:0] == '0) ? POS_MAX : (~smp_q + ONE);
  assign mag_big = (mag_i > mag_q) ? mag_i : mag_q;
  assign mag_sat = (|mag_big[SAMPLE_W-1:PEAK_W]) ? PEAK_MAX : mag_big[PEAK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {seen_valid, seen_nz, seen_busy, seen_neg_i, seen_neg_q} <= '0;
      beat_cnt <= '0;
      peak     <= '0;
    end else if (clear) begin
      {seen_valid, seen_nz, seen_busy, seen_neg_i, seen_neg_q} <= '0;
      beat_cnt <= '0;
      peak     <= '0;
    end else if (smp_valid) begin
      seen_valid <= 1'b1;
      if ((smp_i != '0) || (smp_q != '0)) seen_nz <= 1'b1;
      if (engine_active)                  seen_busy <= 1'b1;
      if (smp_i[SAMPLE_W-1])              seen_neg_i <= 1'b1;
      if (smp_q[SAMPLE_W-1])              seen_neg_q <= 1'b1;
      beat_cnt <= beat_cnt + CNT_ONE;
      if (mag_sat > peak) peak <= mag_sat;
    end
  end

  assign dbg_word = {seen_valid, seen_nz, seen_busy, seen_neg_i, seen_neg_q, beat_cnt, peak};
endmodule

module tap_activity_monitor_chk #(
  parameter int CNT_W  = 13,
  parameter int PEAK_W = 14
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clear,
  input logic                      smp_valid,
  input logic [5+CNT_W+PEAK_W-1:0] dbg_word
);
  localparam int WW = 5 + CNT_W + PEAK_W;

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> dbg_word == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !smp_valid) |=> $stable(dbg_word));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && smp_valid) |=>
      dbg_word[PEAK_W+CNT_W-1:PEAK_W] == CNT_W'($past(dbg_word[PEAK_W+CNT_W-1:PEAK_W]) + 1'b1));

  // R2
  seen_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && smp_valid) |=> dbg_word[WW-1]);

  // R7
  peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> dbg_word[PEAK_W-1:0] >= $past(dbg_word[PEAK_W-1:0]));

  // R3
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (dbg_word[WW-1:WW-5] & $past(dbg_word[WW-1:WW-5])) == $past(dbg_word[WW-1:WW-5]));
endmodule

bind tap_activity_monitor tap_activity_monitor_chk #(.CNT_W(CNT_W), .PEAK_W(PEAK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .smp_valid(smp_valid), .dbg_word(dbg_word)
);

// File: tb/tb_tap_activity_monitor.sv
`timescale 1ns/1ps
module tb_tap_activity_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_i = '0;
  logic [15:0] smp_q = '0;
  logic        engine_active = 1'b0;
  logic [31:0] dbg_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tap_activity_monitor dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .smp_valid(smp_valid),
    .smp_i(smp_i), .smp_q(smp_q), .engine_active(engine_active), .dbg_word(dbg_word)
  );

  function automatic logic [31:0] mk(input logic [4:0] f, input int cnt, input int pk);
    return {f, cnt[12:0], pk[13:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (dbg_word !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, dbg_word, exp);
    end
  endtask

  task automatic beat(input logic [15:0] i, input logic [15:0] q, input logic act);
    @(negedge clk);
    smp_valid = 1'b1; smp_i = i; smp_q = q; engine_active = act;
    @(negedge clk);
    smp_valid = 1'b0; smp_i = '0; smp_q = '0; engine_active = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset value", 32'h0);
  endtask

  task automatic t_idle_ignored();
    @(negedge clk);
    smp_i = 16'h8000; smp_q = 16'h7FFF; engine_active = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 idle inputs ignored", 32'h0);
    smp_i = '0; smp_q = '0; engine_active = 1'b0;
  endtask

  task automatic t_flags_and_peak();
    beat(16'h0000, 16'h0000, 1'b0);
    check("R2 first zero beat", mk(5'b10000, 1, 0));
    beat(16'd100, 16'd50, 1'b0);
    check("R3 nonzero beat", mk(5'b11000, 2, 100));
    beat(-16'sd5, 16'd3, 1'b0);
    check("R5 negative I", mk(5'b11010, 3, 100));
    beat(16'd2, -16'sd200, 1'b0);
    check("R5 negative Q and R7 peak from Q", mk(5'b11011, 4, 200));
    beat(16'd7, 16'd7, 1'b1);
    check("R4 beat while engine active", mk(5'b11111, 5, 200));
    @(negedge clk); smp_i = 16'h8000; smp_q = 16'h8000; engine_active = 1'b1;
    repeat (3) @(negedge clk);
    smp_i = '0; smp_q = '0; engine_active = 1'b0;
    check("R8 held with valid low", mk(5'b11111, 5, 200));
  endtask

  task automatic t_clear_collision();
    @(negedge clk);
    clear = 1'b1; smp_valid = 1'b1; smp_i = 16'h8000; smp_q = 16'h9000; engine_active = 1'b1;
    @(negedge clk);
    clear = 1'b0; smp_valid = 1'b0; smp_i = '0; smp_q = '0; engine_active = 1'b0;
    check("R9 clear wins over beat", 32'h0);
    beat(16'd1, 16'd0, 1'b0);
    check("R9 first beat after clear", mk(5'b11000, 1, 1));
  endtask

  task automatic t_saturation();
    do_clear();
    check("R9 plain clear", 32'h0);
    beat(16'd16000, 16'd0, 1'b0);
    check("R7 peak below limit", mk(5'b11000, 1, 16000));
    beat(16'h8000, 16'd0, 1'b0);
    check("R7 most negative saturates", mk(5'b11010, 2, 16383));
    beat(16'd20, 16'd30, 1'b0);
    check("R7 peak kept", mk(5'b11010, 3, 16383));
    do_clear();
    beat(16'd0, 16'd20000, 1'b0);
    check("R7 large positive saturates", mk(5'b11000, 1, 16383));
  endtask

  task automatic t_wrap();
    do_clear();
    @(negedge clk); smp_valid = 1'b1;
    repeat (8193) @(negedge clk);
    smp_valid = 1'b0;
    check("R6 count wraps modulo 8192", mk(5'b10000, 1, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignored();
    t_flags_and_peak();
    t_clear_collision();
    t_saturation();
    t_wrap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule